// File: doc/BRIEF.md
# ATA PIO Strobe Timing Generator

This block produces the active-low read and write strobes for one parallel ATA channel during programmed-I/O and multiword DMA transfers. A single 32-bit timing word holds two sets of strobe timings, one for accesses to the data port and one for accesses to the task-file command registers. Each set has its own setup delay, active (strobe asserted) time and recovery (strobe released) time. The word also carries four mode-enable flags that the block stores and presents on output pins.

A client raises `req_valid` with a direction and an access kind while `busy` is low. The block then runs one strobe cycle: setup, active and recovery. It pulses `done` in the last recovery clock. The timing word is written through a masked update port. The selected transfer class decides which bits of the stored word a write may replace, so setting PIO timings leaves the DMA-related fields alone and the reverse.

Top module: `ata_pio_strobe_gen`

## Requirements
- R1: While reset is asserted and while `busy` is low, `dior_n` and `diow_n` are high and `done` is low. After reset the stored timing word is zero, so all four flag outputs are 0.
- R2: A data-port cycle (`req_taskfile`=0) holds its strobe low for (word[8:4]+1) clocks, then keeps it high for (word[3:0]+1) recovery clocks.
- R3: A task-file cycle (`req_taskfile`=1) holds its strobe low for (word[17:13]+1) clocks, then keeps it high for (word[12:9]+1) recovery clocks.
- R4: Between acceptance and the first low strobe clock, the strobe stays high for word[24:22] clocks on a data cycle and for word[27:25] clocks on a task-file cycle. A value of 0 means the strobe goes low in the first clock after acceptance.
- R5: A write cycle (`req_write`=1) drives only `diow_n` low and a read cycle drives only `dior_n` low. The two strobes are never low together, and a strobe never hands over directly to the other one.
- R6: `done` is high for exactly one clock, the last recovery clock. `busy` is low in the following clock.
- R7: A request is accepted only at a clock edge where `busy` is low. Holding `req_valid` high while busy does not start a second cycle or stretch the current one.
- R8: The timing fields are captured when a request is accepted. A timing-word write made during a cycle affects only later cycles.
- R9: A write with `cfg_we`=1 replaces only the bits of the stored word set in a mask chosen by `cfg_sel`: 0 (PIO) gives 0xCFC3FFFF, 1 (multiword DMA) gives 0x31C001FF, 2 (UDMA) gives 0x303C0000, and 3 gives all bits. Without `cfg_we` the word does not change.
- R10: The flag outputs show stored bits as follows: `fifo_en` = bit 31, `pio_bm_en` = bit 30, `dma_en` = bit 29, `udma_en` = bit 28.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Apply a masked update to the timing word |
| cfg_sel | input | 2 | Transfer class that picks the update mask |
| cfg_word | input | 32 | New timing word value |
| req_valid | input | 1 | Start a strobe cycle when not busy |
| req_write | input | 1 | 1 = write (diow_n), 0 = read (dior_n) |
| req_taskfile | input | 1 | 1 = task-file register timing, 0 = data-port timing |
| busy | output | 1 | A strobe cycle is in progress |
| dior_n | output | 1 | Active-low read strobe |
| diow_n | output | 1 | Active-low write strobe |
| done | output | 1 | One-clock pulse in the final recovery clock |
| fifo_en | output | 1 | Stored PIO FIFO enable flag |
| pio_bm_en | output | 1 | Stored bus-master PIO enable flag |
| dma_en | output | 1 | Stored DMA enable flag |
| udma_en | output | 1 | Stored UDMA enable flag |

## Verification
The hardest case to reach from the ports is a timing-word write that lands while a cycle is already in its active phase. The stimulus task issues the masked write exactly two clocks after acceptance, with a word whose active and setup fields differ sharply from the running ones. The stretched or shortened strobe then shows at once whether the cycle in flight used the new values. A second difficult case is a request held high across a whole cycle. Here the stimulus keeps `req_valid` asserted until `done` is seen, which checks that no second cycle starts and that the cycle does not get longer. A pseudo-random loop mixes masked writes of all four classes with reads, writes, data and task-file accesses, and compares every clock against a queue-based model.

// File: rtl/ata_strb_pkg.sv
package ata_strb_pkg;

  localparam int WORD_W = 32;

  // field geometry of the packed timing word
  localparam int DRCV_LSB = 0;
  localparam int RCV_W    = 4;
  localparam int DACT_LSB = 4;
  localparam int ACT_W    = 5;
  localparam int CRCV_LSB = 9;
  localparam int CACT_LSB = 13;
  localparam int TIME_W   = CACT_LSB + ACT_W;     // bits covering strobe timings
  localparam int DSET_LSB = 22;
  localparam int SET_W    = 3;
  localparam int CSET_LSB = DSET_LSB + SET_W;
  localparam int FLAG_LSB = 28;
  localparam int FLAG_W   = 4;

  localparam int CNT_W = (ACT_W > RCV_W) ? ((ACT_W > SET_W) ? ACT_W : SET_W)
                                         : ((RCV_W > SET_W) ? RCV_W : SET_W);

  localparam logic [WORD_W-1:0] MASK_PIO   = 32'hCFC3_FFFF;
  localparam logic [WORD_W-1:0] MASK_MWDMA = 32'h31C0_01FF;
  localparam logic [WORD_W-1:0] MASK_UDMA  = 32'h303C_0000;
  localparam logic [WORD_W-1:0] MASK_FULL  = '1;

  typedef enum logic [1:0] {
    CFG_PIO   = 2'd0,
    CFG_MWDMA = 2'd1,
    CFG_UDMA  = 2'd2,
    CFG_FULL  = 2'd3
  } cfg_sel_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_RECOV  = 2'd3
  } phase_e;

  typedef struct packed {
    logic [SET_W-1:0] setup;
    logic [ACT_W-1:0] active;
    logic [RCV_W-1:0] recov;
  } cyc_tim_t;

  function automatic logic [WORD_W-1:0] upd_mask(input cfg_sel_e sel);
    logic [WORD_W-1:0] m;
    case (sel)
      CFG_PIO:   m = MASK_PIO;
      CFG_MWDMA: m = MASK_MWDMA;
      CFG_UDMA:  m = MASK_UDMA;
      default:   m = MASK_FULL;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/ata_strb_timing_reg.sv
module ata_strb_timing_reg
  import ata_strb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  cfg_sel_e          sel,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] word
);

  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] word_d;
  logic [WORD_W-1:0] mask;

  // next-state: merge only the bits the selected class owns
  always_comb begin
    mask   = upd_mask(sel);
    word_d = (word_q & ~mask) | (wdata & mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (we) begin
      word_q <= word_d;
    end
  end

  assign word = word_q;

endmodule

// File: rtl/ata_strb_field_sel.sv
module ata_strb_field_sel
  import ata_strb_pkg::*;
(
  input  logic                 taskfile,
  input  logic [2*SET_W-1:0]   setup_bits,   // {cmd setup, data setup}
  input  logic [TIME_W-1:0]    strb_bits,    // {cmd act, cmd rcv, data act, data rcv}
  output cyc_tim_t             tim
);

  localparam int CSET_OFS = CSET_LSB - DSET_LSB;

  always_comb begin
    if (taskfile) begin
      tim.setup  = setup_bits[CSET_OFS +: SET_W];
      tim.active = strb_bits[CACT_LSB +: ACT_W];
      tim.recov  = strb_bits[CRCV_LSB +: RCV_W];
    end else begin
      tim.setup  = setup_bits[0 +: SET_W];
      tim.active = strb_bits[DACT_LSB +: ACT_W];
      tim.recov  = strb_bits[DRCV_LSB +: RCV_W];
    end
  end

endmodule

// File: rtl/ata_strb_phase_fsm.sv
module ata_strb_phase_fsm
  import ata_strb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic     start_write,
  input  cyc_tim_t tim,
  output logic     busy,
  output logic     dior_n,
  output logic     diow_n,
  output logic     done
);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wr_q;
  logic [ACT_W-1:0] act_q;
  logic [RCV_W-1:0] rcv_q;
  logic             dior_q, dior_d;
  logic             diow_q, diow_d;
  logic             done_q, done_d;
  logic             ld_en;
  logic             wr_eff;

  assign ld_en  = (phase_q == PH_IDLE) && start;
  assign wr_eff = ld_en ? start_write : wr_q;

  // next-state process
  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    case (phase_q)
      PH_IDLE: begin
        if (start) begin
          if (tim.setup != '0) begin
            phase_d = PH_SETUP;
            cnt_d   = CNT_W'(tim.setup) - CNT_W'(1);
          end else begin
            phase_d = PH_ACTIVE;
            cnt_d   = CNT_W'(tim.active);
          end
        end
      end
      PH_SETUP: begin
        if (cnt_q == '0) begin
          phase_d = PH_ACTIVE;
          cnt_d   = CNT_W'(act_q);
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      PH_ACTIVE: begin
        if (cnt_q == '0) begin
          phase_d = PH_RECOV;
          cnt_d   = CNT_W'(rcv_q);
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      PH_RECOV: begin
        if (cnt_q == '0) begin
          phase_d = PH_IDLE;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      default: phase_d = PH_IDLE;
    endcase
    dior_d = !((phase_d == PH_ACTIVE) && !wr_eff);
    diow_d = !((phase_d == PH_ACTIVE) &&  wr_eff);
    done_d = (phase_d == PH_RECOV) && (cnt_d == '0);
  end

  // state and registered strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      dior_q  <= 1'b1;
      diow_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      dior_q  <= dior_d;
      diow_q  <= diow_d;
      done_q  <= done_d;
    end
  end

  // per-cycle capture of direction and timings, enabled on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= 1'b0;
      act_q <= '0;
      rcv_q <= '0;
    end else if (ld_en) begin
      wr_q  <= start_write;
      act_q <= tim.active;
      rcv_q <= tim.recov;
    end
  end

  assign busy   = (phase_q != PH_IDLE);
  assign dior_n = dior_q;
  assign diow_n = diow_q;
  assign done   = done_q;

endmodule

// File: rtl/ata_pio_strobe_gen.sv
module ata_pio_strobe_gen
  import ata_strb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [31:0] cfg_word,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic        req_taskfile,
  output logic        busy,
  output logic        dior_n,
  output logic        diow_n,
  output logic        done,
  output logic        fifo_en,
  output logic        pio_bm_en,
  output logic        dma_en,
  output logic        udma_en
);

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;
  logic [WORD_W-1:0]      word;
  cyc_tim_t               tim;
  logic                   start;
  logic                   busy_w;

  // asynchronous assert, synchronous release
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_sync_q <= '0;
        else        rst_sync_q <= 1'b1;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_sync_q <= '0;
        else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
      end
    end
  endgenerate
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  ata_strb_timing_reg u_treg (
    .clk   (clk),
    .rst_n (rst_int_n),
    .we    (cfg_we),
    .sel   (cfg_sel_e'(cfg_sel)),
    .wdata (cfg_word),
    .word  (word)
  );

  ata_strb_field_sel u_fsel (
    .taskfile   (req_taskfile),
    .setup_bits (word[CSET_LSB+SET_W-1:DSET_LSB]),
    .strb_bits  (word[TIME_W-1:0]),
    .tim        (tim)
  );

  assign start = req_valid && !busy_w;

  ata_strb_phase_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start       (start),
    .start_write (req_write),
    .tim         (tim),
    .busy        (busy_w),
    .dior_n      (dior_n),
    .diow_n      (diow_n),
    .done        (done)
  );

  assign busy      = busy_w;
  assign fifo_en   = word[FLAG_LSB+3];
  assign pio_bm_en = word[FLAG_LSB+2];
  assign dma_en    = word[FLAG_LSB+1];
  assign udma_en   = word[FLAG_LSB];

endmodule

// File: rtl/ata_strb_checker.sv
module ata_strb_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       cfg_we,
  input logic       busy,
  input logic       dior_n,
  input logic       diow_n,
  input logic       done,
  input logic [3:0] flags
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (dior_n && diow_n && !done));

  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dior_n && !diow_n));

  assert_rd_no_swap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !dior_n |=> diow_n);

  assert_wr_no_swap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !diow_n |=> dior_n);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_then_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  assert_done_in_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  assert_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid) |=> busy);

  assert_flags_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(flags));

endmodule

bind ata_pio_strobe_gen ata_strb_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .cfg_we    (cfg_we),
  .busy      (busy),
  .dior_n    (dior_n),
  .diow_n    (diow_n),
  .done      (done),
  .flags     ({fifo_en, pio_bm_en, dma_en, udma_en})
);

// File: tb/ata_pio_strobe_gen_tb_top.sv
module ata_pio_strobe_gen_tb_top;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_word;
  logic        req_valid;
  logic        req_write;
  logic        req_taskfile;
  logic        busy, dior_n, diow_n, done;
  logic        fifo_en, pio_bm_en, dma_en, udma_en;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  ata_pio_strobe_gen dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_word(cfg_word), .req_valid(req_valid), .req_write(req_write),
    .req_taskfile(req_taskfile), .busy(busy), .dior_n(dior_n),
    .diow_n(diow_n), .done(done), .fifo_en(fifo_en),
    .pio_bm_en(pio_bm_en), .dma_en(dma_en), .udma_en(udma_en)
  );

  // 200 MHz
  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // ---------------- reference model ----------------
  // entry: {busy, dior_n, diow_n, done}
  localparam logic [3:0] E_IDLE = 4'b0110;
  logic [3:0]  exp_q[$];
  logic [3:0]  cur;
  logic [31:0] mword;

  function automatic logic [31:0] mask_of(input logic [1:0] s);
    case (s)
      2'd0:    return 32'hCFC3_FFFF;
      2'd1:    return 32'h31C0_01FF;
      2'd2:    return 32'h303C_0000;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q.delete();
      cur   = E_IDLE;
      mword = 32'h0;
    end else begin
      if (!cur[3] && req_valid) begin
        int s_n, a_n, r_n;
        logic [3:0] lo;
        s_n = req_taskfile ? int'(mword[27:25]) : int'(mword[24:22]);
        a_n = req_taskfile ? int'(mword[17:13]) : int'(mword[8:4]);
        r_n = req_taskfile ? int'(mword[12:9])  : int'(mword[3:0]);
        lo  = req_write ? 4'b1100 : 4'b1010;
        for (int i = 0; i < s_n; i++)   exp_q.push_back(4'b1110);
        for (int i = 0; i <= a_n; i++)  exp_q.push_back(lo);
        for (int i = 0; i < r_n; i++)   exp_q.push_back(4'b1110);
        exp_q.push_back(4'b1111);
      end
      if (exp_q.size() > 0) cur = exp_q.pop_front();
      else                  cur = E_IDLE;
      if (cfg_we) mword = (mword & ~mask_of(cfg_sel)) | (cfg_word & mask_of(cfg_sel));
    end
  end

  // per-clock comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      n_checks++;
      if ({busy, dior_n, diow_n, done} !== cur) begin
        n_fail++;
        $display("FAIL R2,R3,R4,R5,R6 model {busy,dior_n,diow_n,done} actual=%b expected=%b at %0t",
                 {busy, dior_n, diow_n, done}, cur, $time);
      end
      n_checks++;
      if ({fifo_en, pio_bm_en, dma_en, udma_en} !== mword[31:28]) begin
        n_fail++;
        $display("FAIL R9,R10 model flags actual=%b expected=%b at %0t",
                 {fifo_en, pio_bm_en, dma_en, udma_en}, mword[31:28], $time);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  task automatic do_cfg(input logic [1:0] sel, input logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_word = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_cycle(input logic wr, input logic tf, input bit hold,
                           input bit mid, input logic [31:0] mw,
                           output int s, output int a, output int r, output int wrong);
    int k;
    bit seen_low, fin;
    logic st, other;
    s = 0; a = 0; r = 0; wrong = 0; k = 0; seen_low = 0; fin = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_taskfile = tf;
    while (!fin) begin
      @(negedge clk);
      k++;
      st    = wr ? diow_n : dior_n;
      other = wr ? dior_n : diow_n;
      if (!other) wrong++;
      if (!st) begin a++; seen_low = 1; end
      else if (!seen_low) s++;
      else r++;
      if (!hold) req_valid = 1'b0;
      if (mid && k == 2) begin cfg_we = 1'b1; cfg_sel = 2'd3; cfg_word = mw; end
      else cfg_we = 1'b0;
      if (done || k > 300) begin fin = 1; req_valid = 1'b0; end
    end
    cfg_we = 1'b0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(5.0 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  // ---------------- stimulus ----------------
  initial begin
    int s, a, r, wr;
    logic [31:0] lfsr;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 2'd0; cfg_word = 32'h0;
    req_valid = 1'b0; req_write = 1'b0; req_taskfile = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy == 1'b0 && dior_n && diow_n && !done, "R1 reset strobes idle", {busy, dior_n, diow_n, done}, 6);
    check({fifo_en, pio_bm_en, dma_en, udma_en} == 4'b0, "R1 reset flags", {fifo_en, pio_bm_en, dma_en, udma_en}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R10: flag positions via full write
    do_cfg(2'd3, 32'hA000_0000);
    check({fifo_en, pio_bm_en, dma_en, udma_en} == 4'b1010, "R10 flag bits", {fifo_en, pio_bm_en, dma_en, udma_en}, 4'b1010);

    // R9: masked updates
    do_cfg(2'd3, 32'h0);
    do_cfg(2'd0, 32'hFFFF_FFFF);
    check({fifo_en, pio_bm_en, dma_en, udma_en} == 4'b1100, "R9 pio mask", {fifo_en, pio_bm_en, dma_en, udma_en}, 4'b1100);
    do_cfg(2'd2, 32'hFFFF_FFFF);
    check({fifo_en, pio_bm_en, dma_en, udma_en} == 4'b1111, "R9 udma mask", {fifo_en, pio_bm_en, dma_en, udma_en}, 4'b1111);
    do_cfg(2'd1, 32'h0);
    check({fifo_en, pio_bm_en, dma_en, udma_en} == 4'b1100, "R9 mwdma mask", {fifo_en, pio_bm_en, dma_en, udma_en}, 4'b1100);

    // timings: data setup 2 act 3 rcv 1; taskfile setup 1 act 6 rcv 4
    do_cfg(2'd3, 32'h0280_C831);
    run_cycle(1'b0, 1'b0, 1'b0, 1'b0, 32'h0, s, a, r, wr);
    check(s == 2, "R4 data setup", s, 2);
    check(a == 4, "R2 data active", a, 4);
    check(r == 2, "R2 data recovery", r, 2);
    check(wr == 0, "R5 read uses dior_n only", wr, 0);
    @(negedge clk);
    check(!busy, "R6 idle after done", busy, 0);

    run_cycle(1'b1, 1'b1, 1'b0, 1'b0, 32'h0, s, a, r, wr);
    check(s == 1, "R4 taskfile setup", s, 1);
    check(a == 7, "R3 taskfile active", a, 7);
    check(r == 5, "R3 taskfile recovery", r, 5);
    check(wr == 0, "R5 write uses diow_n only", wr, 0);

    // R8: mid-cycle rewrite does not affect running cycle
    run_cycle(1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_00F0, s, a, r, wr);
    check(s == 2 && a == 4 && r == 2, "R8 running cycle keeps timings", a, 4);
    run_cycle(1'b0, 1'b0, 1'b0, 1'b0, 32'h0, s, a, r, wr);
    check(s == 0, "R4 zero setup", s, 0);
    check(a == 16, "R8 new word used next cycle", a, 16);
    check(r == 1, "R2 minimum recovery", r, 1);

    // R7: request held through the whole cycle
    run_cycle(1'b1, 1'b1, 1'b1, 1'b0, 32'h0, s, a, r, wr);
    check(s == 0 && a == 1 && r == 1, "R7 held request single cycle", a, 1);
    @(negedge clk);
    check(!busy && dior_n && diow_n, "R7 no second cycle", busy, 0);

    // mixed pseudo-random traffic against the model
    lfsr = 32'h1D2C_3B4A;
    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      do_cfg(lfsr[1:0], {lfsr[15:0], lfsr[31:16]} ^ 32'h5A5A_3C3C);
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      run_cycle(lfsr[2], lfsr[3], lfsr[4], lfsr[5], lfsr ^ 32'h0F0F_F0F0, s, a, r, wr);
      check(wr == 0, "R5 random opposite strobe", wr, 0);
    end
    repeat (4) @(negedge clk);
    summary();
  end

endmodule